// File: doc/BRIEF.md
# ECP Extended Control Register Unit

This unit holds the configuration and extended-control registers of a parallel port that can run the ECP protocol. A host reaches it over a plain 8-bit register bus with an address, a read strobe and a write strobe. Two of the registers are fixed configuration words for discovery software. The third is the extended control register. It holds the port mode, an active-low enable for error interrupts, a DMA enable and a service bit that hardware sets.

The unit watches the external nFault line and produces one interrupt pulse output. Interrupts come from falling edges of nFault and from service events. The FIFO and DMA engines elsewhere in the port report these events as single-cycle pulses: terminal count, write threshold and read threshold. The unit also produces a DMA qualifier that the DMA engine uses. Two rules keep interrupts from being lost. First, clearing the error-interrupt enable while nFault is already low raises an interrupt. Second, the service bit latches high on every service interrupt, so software must re-arm it before another one can occur.

Top module: `ecpExtCtrl`

## Requirements
- R1: After reset the extended control register reads 0x04 (mode 000, bit 4 = 0, bit 3 = 0, bit 2 = 1), intrOut is 0 and dmaActive is 0.
- R2: A read of offset 0x400 returns 0x10. Writes to 0x400 have no effect on any register.
- R3: A read of offset 0x401 returns {1'b0, intrOut, cfgIrqSel[2:0], cfgDmaSel[2:0]}, with bit 7 constant 0 and bit 6 the live interrupt output. Writes to 0x401 are ignored.
- R4: Offset 0x402 stores wrData[7:2] on a write (mode in 7:5, error-interrupt disable in 4, DMA enable in 3, service bit in 2) and reads back with bits 1:0 at 0. Any other offset reads 0x00, and rdData is 0x00 while rdEn is low.
- R5: In ECP mode (mode 011) with bit 4 = 0, a high-to-low change on nFault produces a one-cycle intrOut pulse. The pulse appears in the third clock cycle after the change, because of two synchronising stages and one edge stage. With bit 4 = 1, or in any other mode, nFault edges are ignored.
- R6: In ECP mode, a write that changes bit 4 from 1 to 0 while the synchronised nFault is low produces a one-cycle intrOut pulse in the cycle after the write.
- R7: dmaActive is 1 exactly when bit 3 is 1 and bit 2 is 0.
- R8: While bit 2 is 0, the following events each produce a one-cycle intrOut pulse in the next cycle and set bit 2 to 1: a tcPulse with bit 3 = 1, or a wrThrPulse or rdThrPulse with bit 3 = 0. While bit 2 is 1 these events are ignored. An event wins over a write to 0x402 in the same cycle.
- R9: Software writing bit 2 to 1 never produces an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset from port base |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| cfgIrqSel | input | 3 | Configured IRQ selection reported in 0x401 |
| cfgDmaSel | input | 3 | Configured DMA channel reported in 0x401 |
| nFault | input | 1 | Asynchronous peripheral fault line, active low |
| tcPulse | input | 1 | DMA terminal count event |
| wrThrPulse | input | 1 | FIFO write threshold event |
| rdThrPulse | input | 1 | FIFO read threshold event |
| intrOut | output | 1 | One-cycle interrupt pulse |
| dmaActive | output | 1 | DMA qualifier |

## Verification
nFault falling edges are applied in four setups: ECP mode enabled, ECP mode masked by bit 4, a non-ECP mode, and a masked edge later unmasked by a write while the line stays low. Together these separate the edge path from the level-based write-clear path. Service events are sent in both DMA-enable states, with the service bit clear and set, and once in the same cycle as a register write. This shows which events qualify, that the latch blocks further interrupts, and that the event wins over the write. Reads cover every implemented offset, neighbouring unimplemented offsets and an idle read strobe. A cycle-by-cycle model compares rdData, intrOut and dmaActive throughout.

// File: rtl/ecpExtCtrlPkg.sv
package ecpExtCtrlPkg;
  localparam int unsigned CFGA_OFS = 32'h400;
  localparam int unsigned CFGB_OFS = 32'h401;
  localparam int unsigned ECR_OFS  = 32'h402;
  localparam logic [7:0]  CFGA_VAL = 8'h10;
  localparam logic [2:0]  MODE_ECP = 3'b011;

  // extended control register fields, msb first as stored in bits 7:2
  typedef struct packed {
    logic [2:0] mode;
    logic       errDis;
    logic       dmaEn;
    logic       svc;
  } ecrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ecrWr;
    logic svcSet;
    logic intrFire;
  } ctlStrb_t;
endpackage

// File: rtl/ecpCtrlPath.sv
module ecpCtrlPath
  import ecpExtCtrlPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              wrErrDis,
  input  logic              nFault,
  input  logic              tcPulse,
  input  logic              wrThrPulse,
  input  logic              rdThrPulse,
  input  ecrState_t         ecr,
  output ctlStrb_t          strb
);
  localparam logic [ADDR_W-1:0] ECR_ADDR = ADDR_W'(ECR_OFS);

  logic [SYNC_STAGES-1:0] syncQ;
  logic faultLvl, faultPrev;
  logic ecpMode, ecrWr, fallHit, wrClrHit, svcHit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= nFault;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], nFault};
    end
  endgenerate

  assign faultLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) faultPrev <= 1'b1;
    else       faultPrev <= faultLvl;

  assign ecpMode  = (ecr.mode == MODE_ECP);
  assign ecrWr    = wrEn && (addr == ECR_ADDR);
  assign fallHit  = ecpMode && !ecr.errDis && faultPrev && !faultLvl;
  assign wrClrHit = ecrWr && ecpMode && ecr.errDis && !wrErrDis && !faultLvl;
  assign svcHit   = !ecr.svc &&
                    ((tcPulse && ecr.dmaEn) ||
                     ((wrThrPulse || rdThrPulse) && !ecr.dmaEn));

  always_comb begin
    strb.ecrWr    = ecrWr;
    strb.svcSet   = svcHit;
    strb.intrFire = fallHit || wrClrHit || svcHit;
  end
endmodule

// File: rtl/ecpRegPath.sv
module ecpRegPath
  import ecpExtCtrlPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  input  logic [2:0]        cfgIrqSel,
  input  logic [2:0]        cfgDmaSel,
  input  ctlStrb_t          strb,
  output ecrState_t         ecr,
  output logic              intrOut,
  output logic              dmaActive,
  output logic [7:0]        rdData
);
  localparam logic [ADDR_W-1:0] CFGA_ADDR = ADDR_W'(CFGA_OFS);
  localparam logic [ADDR_W-1:0] CFGB_ADDR = ADDR_W'(CFGB_OFS);
  localparam logic [ADDR_W-1:0] ECR_ADDR  = ADDR_W'(ECR_OFS);
  localparam ecrState_t         ECR_RST   = '{mode: 3'b000, errDis: 1'b0, dmaEn: 1'b0, svc: 1'b1};

  logic unusedLowBits;
  assign unusedLowBits = ^wrData[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ecr     <= ECR_RST;
      intrOut <= 1'b0;
    end else begin
      if (strb.ecrWr)  ecr     <= ecrState_t'(wrData[7:2]);
      if (strb.svcSet) ecr.svc <= 1'b1;
      intrOut <= strb.intrFire;
    end
  end

  assign dmaActive = ecr.dmaEn && !ecr.svc;

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      if (addr == CFGA_ADDR)      rdData = CFGA_VAL;
      else if (addr == CFGB_ADDR) rdData = {1'b0, intrOut, cfgIrqSel, cfgDmaSel};
      else if (addr == ECR_ADDR)  rdData = {ecr, 2'b00};
    end
  end
endmodule

// File: rtl/ecpExtCtrl.sv
module ecpExtCtrl
  import ecpExtCtrlPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [2:0]        cfgIrqSel,
  input  logic [2:0]        cfgDmaSel,
  input  logic              nFault,
  input  logic              tcPulse,
  input  logic              wrThrPulse,
  input  logic              rdThrPulse,
  output logic              intrOut,
  output logic              dmaActive
);
  ctlStrb_t  strb;
  ecrState_t ecr;

  ecpCtrlPath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrErrDis(wrData[4]),
    .nFault(nFault), .tcPulse(tcPulse), .wrThrPulse(wrThrPulse),
    .rdThrPulse(rdThrPulse), .ecr(ecr), .strb(strb)
  );

  ecpRegPath #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrData(wrData),
    .cfgIrqSel(cfgIrqSel), .cfgDmaSel(cfgDmaSel), .strb(strb), .ecr(ecr),
    .intrOut(intrOut), .dmaActive(dmaActive), .rdData(rdData)
  );
endmodule

// File: rtl/ecpExtCtrlChk.sv
module ecpExtCtrlChk
  import ecpExtCtrlPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic              intrOut,
  input logic              dmaActive,
  input ctlStrb_t          strb,
  input ecrState_t         ecr
);
  p_cfga_const_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(CFGA_OFS)) |-> rdData == CFGA_VAL);

  p_cfgb_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(CFGB_OFS)) |-> (!rdData[7] && rdData[6] == intrOut));

  p_svc_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.svcSet |=> (ecr.svc && intrOut));

  p_svc_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    ecr.svc |-> !strb.svcSet);

  p_dma_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.svcSet |=> !dmaActive);

  p_intr_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    intrOut |-> $past(strb.intrFire));
endmodule

bind ecpExtCtrl ecpExtCtrlChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .rdData(rdData),
  .intrOut(intrOut), .dmaActive(dmaActive), .strb(strb), .ecr(ecr)
);

// File: tb/ecpExtCtrl_tb.sv
`timescale 1ns/1ps
module ecpExtCtrl_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [10:0] addr = '0;
  logic        rdEn = 0, wrEn = 0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [2:0]  cfgIrqSel = 3'd5, cfgDmaSel = 3'd3;
  logic        nFault = 1;
  logic        tcPulse = 0, wrThrPulse = 0, rdThrPulse = 0;
  logic        intrOut, dmaActive;

  int nChecks = 0, nFail = 0, pulseCnt = 0;
  string curReq = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  ecpExtCtrl u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfgIrqSel(cfgIrqSel), .cfgDmaSel(cfgDmaSel), .nFault(nFault),
    .tcPulse(tcPulse), .wrThrPulse(wrThrPulse), .rdThrPulse(rdThrPulse),
    .intrOut(intrOut), .dmaActive(dmaActive)
  );

  // behavioural reference model
  int  mMode = 0;
  bit  mErrDis = 0, mDmaEn = 0, mSvc = 1, mIntr = 0;
  bit  faultHist[$] = '{1'b1, 1'b1, 1'b1};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mErrDis = 0; mDmaEn = 0; mSvc = 1; mIntr = 0;
      faultHist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit lvl, prv, ecpM, wr, fall, clr, svcE;
      lvl  = faultHist[1];
      prv  = faultHist[2];
      ecpM = (mMode == 3);
      wr   = wrEn && (addr == 11'h402);
      fall = ecpM && !mErrDis && prv && !lvl;
      clr  = wr && ecpM && mErrDis && !wrData[4] && !lvl;
      svcE = !mSvc && ((tcPulse && mDmaEn) || ((wrThrPulse || rdThrPulse) && !mDmaEn));
      mIntr = fall || clr || svcE;
      if (wr) begin
        mMode = int'(wrData[7:5]); mErrDis = wrData[4]; mDmaEn = wrData[3]; mSvc = wrData[2];
      end
      if (svcE) mSvc = 1;
      faultHist.push_front(nFault);
      void'(faultHist.pop_back());
    end
  end

  function automatic int expRead();
    if (!rdEn) return 0;
    case (addr)
      11'h400: return 'h10;
      11'h401: return {1'b0, mIntr, cfgIrqSel, cfgDmaSel};
      11'h402: return {mMode[2:0], mErrDis, mDmaEn, mSvc, 2'b00};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always begin
    @(posedge clk);
    #2;
    if (rstN && !done) begin
      chk({curReq, " intrOut"}, int'(intrOut), int'(mIntr));
      chk({curReq, " dmaActive"}, int'(dmaActive), int'(mDmaEn && !mSvc));
      chk({curReq, " rdData"}, int'(rdData), expRead());
      if (intrOut) pulseCnt++;
    end
  end

  task automatic wrReg(input int a, input int d);
    @(negedge clk); addr = 11'(a); wrData = 8'(d); wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    @(negedge clk); addr = 11'(a); rdEn = 1;
    #1 chk(tag, int'(rdData), exp);
    #1 rdEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countChk(input int exp, input string tag);
    idle(6);
    chk(tag, pulseCnt, exp);
    pulseCnt = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1 reset state
    curReq = "R1";
    @(negedge clk); #1;
    chk("R1 intrOut", int'(intrOut), 0);
    chk("R1 dmaActive", int'(dmaActive), 0);
    rdChk('h402, 'h04, "R1 ecr reset");

    // R2 fixed configuration word
    curReq = "R2";
    rdChk('h400, 'h10, "R2 cfgA");
    wrReg('h400, 'hFF);
    rdChk('h400, 'h10, "R2 cfgA after write");
    rdChk('h402, 'h04, "R2 ecr untouched");

    // R3 second configuration word
    curReq = "R3";
    rdChk('h401, 'h2B, "R3 cfgB");
    wrReg('h401, 'hFF);
    rdChk('h401, 'h2B, "R3 cfgB after write");

    // R4 storage, masking, decode
    curReq = "R4";
    wrReg('h402, 'hFF);
    rdChk('h402, 'hFC, "R4 ecr all ones");
    rdChk('h403, 'h00, "R4 offset 0x403");
    rdChk('h3FF, 'h00, "R4 offset 0x3FF");
    @(negedge clk); addr = 11'h400; rdEn = 0; #1 chk("R4 idle read", int'(rdData), 0);
    wrReg('h402, 'h04);
    countChk(0, "R4 no pulse");

    // R5 fault edge in ECP mode
    curReq = "R5";
    wrReg('h402, 'h64);
    @(negedge clk); nFault = 0; addr = 11'h401; rdEn = 1;
    countChk(1, "R5 edge pulse count");
    rdEn = 0; nFault = 1; idle(4);
    wrReg('h402, 'h24);                 // mode 001
    @(negedge clk); nFault = 0;
    countChk(0, "R5 non-ECP edge ignored");
    nFault = 1; idle(4);
    wrReg('h402, 'h74);                 // ECP, errDis = 1
    @(negedge clk); nFault = 0;
    countChk(0, "R5 masked edge ignored");

    // R6 unmask while nFault already low
    curReq = "R6";
    wrReg('h402, 'h64);
    countChk(1, "R6 write-clear pulse");
    nFault = 1; idle(4);
    wrReg('h402, 'h04);

    // R7 DMA qualifier
    curReq = "R7";
    wrReg('h402, 'h08); #1 chk("R7 en=1 svc=0", int'(dmaActive), 1);
    wrReg('h402, 'h0C); #1 chk("R7 en=1 svc=1", int'(dmaActive), 0);
    wrReg('h402, 'h00); #1 chk("R7 en=0 svc=0", int'(dmaActive), 0);

    // R8 service events
    curReq = "R8";
    @(negedge clk); wrThrPulse = 1; @(negedge clk); wrThrPulse = 0;
    countChk(1, "R8 write threshold");
    rdChk('h402, 'h04, "R8 svc latched");
    @(negedge clk); rdThrPulse = 1; @(negedge clk); rdThrPulse = 0;
    countChk(0, "R8 blocked while svc set");
    wrReg('h402, 'h00);
    @(negedge clk); rdThrPulse = 1; @(negedge clk); rdThrPulse = 0;
    countChk(1, "R8 read threshold");
    wrReg('h402, 'h08);
    @(negedge clk); wrThrPulse = 1; @(negedge clk); wrThrPulse = 0;
    countChk(0, "R8 threshold with DMA on ignored");
    @(negedge clk); tcPulse = 1; @(negedge clk); tcPulse = 0;
    countChk(1, "R8 terminal count");
    rdChk('h402, 'h0C, "R8 svc after tc");
    wrReg('h402, 'h08);
    @(negedge clk); addr = 11'h402; wrData = 8'h08; wrEn = 1; tcPulse = 1;
    @(negedge clk); wrEn = 0; tcPulse = 0;
    rdChk('h402, 'h0C, "R8 event beats write");
    countChk(1, "R8 same-cycle pulse");

    // R9 software set of service bit
    curReq = "R9";
    wrReg('h402, 'h00);
    wrReg('h402, 'h04);
    countChk(0, "R9 no pulse on svc write");
    rdChk('h402, 'h04, "R9 svc reads set");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule